// File: doc/BRIEF.md
# Linked Descriptor Queue Walker

This engine looks after one queue of DMA descriptors that sit in a shared SRAM. It holds two registers: a head pointer and a terminator pointer. The queue is empty whenever the two are equal. A descriptor takes five 32-bit words:

| Offset | Contents |
|---|---|
| +0 | status in bits [15:0], control in bits [31:16] |
| +4 | data size and total length |
| +8 | pointer to the last descriptor of the packet's chain |
| +12 | data buffer address |
| +16 | next-descriptor pointer |

The low two bits of the status word hold the ownership field: 0 is software, 1 is hardware, and 2 is a third state. A packet can span several descriptors. The engine removes a whole packet in one hop by following the head's last-of-chain pointer and then that descriptor's next pointer.

Commands arrive through a valid/ready handshake. The engine takes a command only when it is idle, and it ends every command with a one-cycle `done` pulse. It reaches memory through a synchronous port: `mem_addr` is a word-aligned byte address, and read data comes back one cycle after the request. It makes one access per 32-bit field.

The state machine has these states:
- IDLE accepts a command.
- STAT_REQ and STAT_CAP read the head's status word.
- LAST_REQ and LAST_CAP fetch the last-of-chain pointer.
- NEXT_REQ and NEXT_CAP fetch that descriptor's next pointer and load it into head.
- RA_REQ, RA_CAP and RA_WR carry out the re-arm read-modify-write.
- CNT_STEP and CNT_CAP walk the next pointers for a count.
- DONE pulses `done` and returns to IDLE.

The transitions are:
- From IDLE:
  - Pointer loads, the empty test and unknown opcodes go straight to DONE.
  - Own tests and dequeues go to DONE when the queue is empty, and to STAT_REQ otherwise.
  - A re-arm goes to RA_REQ.
  - A count goes to CNT_STEP.
- STAT_CAP goes to LAST_REQ when a dequeue's condition holds, and to DONE otherwise.
- The chain LAST_REQ→LAST_CAP→NEXT_REQ→NEXT_CAP→DONE runs in order.
- The chain RA_REQ→RA_CAP→RA_WR→DONE runs in order.
- CNT_STEP goes to CNT_CAP while the walk goes on, and to DONE at the terminator or at the cap. CNT_CAP always returns to CNT_STEP.

Top module: `desc_queue_walker`

## Requirements
- R1: After reset, head and terminator are both 0, `cmd_ready` is 1, and `done` and `mem_req` are 0.
- R2: Opcode 0 loads `cmd_addr` into head and opcode 1 loads it into the terminator. Opcode 2 returns `res_flag`=1 exactly when head equals the terminator, and returns the current head in `res_addr`.
- R3: Opcode 3 on a non-empty queue returns bits [1:0] of the word at head+0 in `res_own`, and sets `res_flag`=1 when they equal `cmd_own`. On an empty queue it returns `res_null`=1.
- R4: Opcode 4 (unconditional dequeue) on a non-empty queue returns the old head in `res_addr` with `res_null`=0. The new head becomes the word at L+16, where L is the word at old head+8.
- R5: Opcode 5 dequeues only when the head's ownership equals `cmd_own`, and opcode 6 only when it differs. A failed condition gives `res_null`=1 and leaves head unchanged.
- R6: A dequeue or own test on an empty queue gives `res_null`=1, leaves head unchanged and makes no memory access.
- R7: Opcode 7 reads the word at `cmd_addr` and writes it back with bits [1:0]=01 and all other bits unchanged. It returns `cmd_addr` in `res_addr`.
- R8: Opcode 8 follows +16 next pointers from head until it reaches the terminator, and returns the number of hops in `res_count` with `res_err`=0.
- R9: When the count reaches MAX_WALK hops without meeting the terminator, it stops with `res_err`=1 and `res_count`=MAX_WALK.
- R10: `done` is a single-cycle pulse. `cmd_ready` is low from acceptance until after `done`. Every `mem_addr` is word-aligned. Opcodes 9 to 15 complete with `res_null`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; command taken when both high |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | 32 | Pointer operand (load value or re-arm target) |
| cmd_own | input | 2 | Ownership value for tests and conditional dequeue |
| done | output | 1 | Command complete pulse |
| res_addr | output | 32 | Result address |
| res_null | output | 1 | No descriptor returned |
| res_flag | output | 1 | Empty / ownership match flag |
| res_own | output | 2 | Ownership field read from head |
| res_count | output | clog2(MAX_WALK+1) | Sub-descriptor count |
| res_err | output | 1 | Count cap reached |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable |
| mem_addr | output | 32 | Byte address, word-aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |

## Verification
The bench goes after several corner cases:
- Multi-descriptor packets. A walker that steps one descriptor at a time would leave head inside a packet.
- Dequeues on an empty queue. A design that skipped the empty test would issue reads and move head onto garbage.
- Failed ownership conditions. A design that checked a condition wrongly would remove hardware-owned packets.
- Re-arming words with every upper bit set. A write that did not preserve the rest of the word would clear control flags.
- Count chains of exactly MAX_WALK, MAX_WALK+1 and a loop. An off-by-one in the cap either flags a legal full-length chain or keeps walking a corrupted one.

// File: rtl/dqw_pkg.sv
package dqw_pkg;

    typedef enum logic [3:0] {
        OP_SET_HEAD = 4'd0,
        OP_SET_TERM = 4'd1,
        OP_EMPTY    = 4'd2,
        OP_TEST_OWN = 4'd3,
        OP_DEQ_ANY  = 4'd4,
        OP_DEQ_EQ   = 4'd5,
        OP_DEQ_NE   = 4'd6,
        OP_REARM    = 4'd7,
        OP_COUNT    = 4'd8
    } dqw_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STAT_REQ,
        S_STAT_CAP,
        S_LAST_REQ,
        S_LAST_CAP,
        S_NEXT_REQ,
        S_NEXT_CAP,
        S_RA_REQ,
        S_RA_CAP,
        S_RA_WR,
        S_CNT_STEP,
        S_CNT_CAP,
        S_DONE
    } dqw_state_e;

    // word offsets inside one descriptor (byte units)
    localparam logic [31:0] OFF_STAT = 32'd0;
    localparam logic [31:0] OFF_LAST = 32'd8;
    localparam logic [31:0] OFF_NEXT = 32'd16;

    localparam logic [1:0] OWN_HW = 2'b01;

endpackage

// File: rtl/dqw_ptr_regs.sv
module dqw_ptr_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        head_ld,
    input  logic [31:0] head_val,
    input  logic        term_ld,
    input  logic [31:0] term_val,
    output logic [31:0] head_q,
    output logic [31:0] term_q,
    output logic        is_empty
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            term_q <= '0;
        end else begin
            if (head_ld) head_q <= head_val;
            if (term_ld) term_q <= term_val;
        end
    end

    assign is_empty = (head_q == term_q);

endmodule

// File: rtl/dqw_own_cond.sv
module dqw_own_cond
    import dqw_pkg::*;
(
    input  logic [3:0] op,
    input  logic [1:0] own,
    input  logic [1:0] want,
    output logic       match,
    output logic       pass
);

    always_comb begin
        match = (own == want);
        case (op)
            OP_DEQ_ANY: pass = 1'b1;
            OP_DEQ_EQ:  pass = match;
            OP_DEQ_NE:  pass = !match;
            default:    pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/dqw_walk_ctr.sv
module dqw_walk_ctr #(
    parameter int MAX_WALK = 64,
    parameter int CNT_W    = $clog2(MAX_WALK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_cap
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + CNT_W'(1);
    end

    assign at_cap = (count == CNT_W'(MAX_WALK));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX_WALK)); // R9

    AST_NO_INC_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_cap); // R9

endmodule

// File: rtl/desc_queue_walker.sv
module desc_queue_walker
    import dqw_pkg::*;
#(
    parameter  int MAX_WALK = 64,
    localparam int CNT_W    = $clog2(MAX_WALK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [3:0]       cmd_op,
    input  logic [31:0]      cmd_addr,
    input  logic [1:0]       cmd_own,
    output logic             done,
    output logic [31:0]      res_addr,
    output logic             res_null,
    output logic             res_flag,
    output logic [1:0]       res_own,
    output logic [CNT_W-1:0] res_count,
    output logic             res_err,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata
);

    dqw_state_e  state_q, state_d;
    logic [3:0]  op_q;
    logic [31:0] arg_q;
    logic [1:0]  want_q;
    logic [31:0] ptr_q;

    logic        head_ld, term_ld;
    logic [31:0] head_val;
    logic [31:0] head_q, term_q;
    logic        is_empty;
    logic        ctr_clr, ctr_inc, at_cap;
    logic        own_match, own_pass;
    logic        accept, acc_qop;

    dqw_ptr_regs u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .head_ld  (head_ld),
        .head_val (head_val),
        .term_ld  (term_ld),
        .term_val (cmd_addr),
        .head_q   (head_q),
        .term_q   (term_q),
        .is_empty (is_empty)
    );

    dqw_own_cond u_cond (
        .op    (op_q),
        .own   (mem_rdata[1:0]),
        .want  (want_q),
        .match (own_match),
        .pass  (own_pass)
    );

    dqw_walk_ctr #(.MAX_WALK(MAX_WALK), .CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctr_clr),
        .inc    (ctr_inc),
        .count  (res_count),
        .at_cap (at_cap)
    );

    assign accept  = cmd_valid && cmd_ready;
    assign acc_qop = (cmd_op == OP_TEST_OWN) || (cmd_op == OP_DEQ_ANY) ||
                     (cmd_op == OP_DEQ_EQ)   || (cmd_op == OP_DEQ_NE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cmd_ready = 1'b0;
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        head_ld   = 1'b0;
        head_val  = mem_rdata;
        term_ld   = 1'b0;
        ctr_clr   = 1'b0;
        ctr_inc   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_SET_HEAD: begin
                            head_ld  = 1'b1;
                            head_val = cmd_addr;
                            state_d  = S_DONE;
                        end
                        OP_SET_TERM: begin
                            term_ld = 1'b1;
                            state_d = S_DONE;
                        end
                        OP_TEST_OWN, OP_DEQ_ANY, OP_DEQ_EQ, OP_DEQ_NE:
                            state_d = is_empty ? S_DONE : S_STAT_REQ;
                        OP_REARM: state_d = S_RA_REQ;
                        OP_COUNT: begin
                            ctr_clr = 1'b1;
                            state_d = S_CNT_STEP;
                        end
                        default: state_d = S_DONE;
                    endcase
                end
            end
            S_STAT_REQ: begin
                mem_req  = 1'b1;
                mem_addr = head_q + OFF_STAT;
                state_d  = S_STAT_CAP;
            end
            S_STAT_CAP: begin
                if (op_q != OP_TEST_OWN && own_pass) state_d = S_LAST_REQ;
                else                                 state_d = S_DONE;
            end
            S_LAST_REQ: begin
                mem_req  = 1'b1;
                mem_addr = head_q + OFF_LAST;
                state_d  = S_LAST_CAP;
            end
            S_LAST_CAP: state_d = S_NEXT_REQ;
            S_NEXT_REQ: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + OFF_NEXT;
                state_d  = S_NEXT_CAP;
            end
            S_NEXT_CAP: begin
                head_ld  = 1'b1;
                head_val = mem_rdata;
                state_d  = S_DONE;
            end
            S_RA_REQ: begin
                mem_req  = 1'b1;
                mem_addr = arg_q + OFF_STAT;
                state_d  = S_RA_CAP;
            end
            S_RA_CAP: state_d = S_RA_WR;
            S_RA_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = arg_q + OFF_STAT;
                mem_wdata = ptr_q;
                state_d   = S_DONE;
            end
            S_CNT_STEP: begin
                if (ptr_q == term_q || at_cap) begin
                    state_d = S_DONE;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = ptr_q + OFF_NEXT;
                    state_d  = S_CNT_CAP;
                end
            end
            S_CNT_CAP: begin
                ctr_inc = 1'b1;
                state_d = S_CNT_STEP;
            end
            S_DONE: begin
                done    = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // operand and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            arg_q    <= '0;
            want_q   <= '0;
            ptr_q    <= '0;
            res_addr <= '0;
            res_null <= 1'b0;
            res_flag <= 1'b0;
            res_own  <= '0;
            res_err  <= 1'b0;
        end else begin
            if (accept) begin
                op_q     <= cmd_op;
                arg_q    <= cmd_addr;
                want_q   <= cmd_own;
                ptr_q    <= head_q;
                res_addr <= head_q;
                res_null <= 1'b0;
                res_flag <= 1'b0;
                res_own  <= '0;
                res_err  <= 1'b0;
                case (cmd_op)
                    OP_EMPTY: res_flag <= is_empty;
                    OP_TEST_OWN, OP_DEQ_ANY, OP_DEQ_EQ, OP_DEQ_NE:
                        res_null <= is_empty;
                    OP_SET_HEAD, OP_SET_TERM, OP_REARM: res_addr <= cmd_addr;
                    OP_COUNT: ;
                    default: res_null <= 1'b1;
                endcase
            end
            case (state_q)
                S_STAT_CAP: begin
                    res_own  <= mem_rdata[1:0];
                    res_flag <= own_match;
                    if (op_q != OP_TEST_OWN && !own_pass) res_null <= 1'b1;
                end
                S_LAST_CAP: ptr_q <= mem_rdata;
                S_RA_CAP:   ptr_q <= {mem_rdata[31:2], OWN_HW};
                S_CNT_CAP:  ptr_q <= mem_rdata;
                S_CNT_STEP: if (ptr_q != term_q && at_cap) res_err <= 1'b1;
                default: ;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R10

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !cmd_ready); // R10

    AST_EMPTY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_qop && is_empty) |=> !mem_req); // R6

    AST_REARM_OWN_HW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[1:0] == OWN_HW)); // R7

    AST_REARM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[31:2] == $past(mem_rdata[31:2]))); // R7

    AST_ERR_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_err) |-> (res_count == CNT_W'(MAX_WALK))); // R9

endmodule

// File: tb/sim_desc_queue_walker.sv
module sim_desc_queue_walker;
    import dqw_pkg::*;

    localparam int MAXW = 16;
    localparam int CW   = $clog2(MAXW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [3:0]    cmd_op = '0;
    logic [31:0]   cmd_addr = '0;
    logic [1:0]    cmd_own = '0;
    logic          done;
    logic [31:0]   res_addr;
    logic          res_null, res_flag, res_err;
    logic [1:0]    res_own;
    logic [CW-1:0] res_count;
    logic          mem_req, mem_we;
    logic [31:0]   mem_addr, mem_wdata;
    logic [31:0]   rd_q = '0;

    logic [31:0] mem [0:255];
    int vecs = 0;
    int fails = 0;
    int nreq = 0;
    logic [31:0] exp_head = '0;
    logic [31:0] exp_term = '0;

    always #10 clk = ~clk;

    desc_queue_walker #(.MAX_WALK(MAXW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_own(cmd_own),
        .done(done), .res_addr(res_addr), .res_null(res_null), .res_flag(res_flag),
        .res_own(res_own), .res_count(res_count), .res_err(res_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(rd_q)
    );

    // memory model: one cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            nreq = nreq + 1;
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            else        rd_q <= mem[mem_addr[9:2]];
        end
    end

    function automatic logic [31:0] dadr(input int i);
        return 32'd64 + 32'(20 * i);
    endfunction

    function automatic logic [31:0] rw(input logic [31:0] a);
        return mem[a[9:2]];
    endfunction

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        mem[a[9:2]] = d;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [3:0] op, input logic [31:0] a, input logic [1:0] b);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_own = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic set_queue(input logic [31:0] h, input logic [31:0] t);
        run_cmd(OP_SET_HEAD, h, 2'd0);
        run_cmd(OP_SET_TERM, t, 2'd0);
        exp_head = h; exp_term = t;
    endtask

    task automatic probe_head(input string req);
        run_cmd(OP_EMPTY, 32'd0, 2'd0);
        chk(req, res_addr, exp_head);
        chk(req, {31'd0, res_flag}, {31'd0, exp_head == exp_term});
    endtask

    task automatic put_desc(input int i, input logic [31:0] st, input int last, input int nxt);
        wr(dadr(i) + 0,  st);
        wr(dadr(i) + 4,  $urandom);
        wr(dadr(i) + 8,  dadr(last));
        wr(dadr(i) + 12, $urandom);
        wr(dadr(i) + 16, dadr(nxt));
    endtask

    task automatic build_rand(output int nd);
        int k = 1;
        int npk = 1 + int'($urandom % 5);
        put_desc(0, 32'h0, 0, 0);
        for (int p = 0; p < npk; p++) begin
            int len = 1 + int'($urandom % 3);
            int l = k + len - 1;
            logic [31:0] st = {$urandom} & 32'hFFFF_FFFC;
            st[1:0] = 2'($urandom % 3);
            for (int j = k; j <= l; j++)
                put_desc(j, st, l, (j == l && p == npk - 1) ? 0 : j + 1);
            k = l + 1;
        end
        nd = k - 1;
    endtask

    task automatic build_linear(input int n, input bit loop_back);
        put_desc(0, 32'h0, 0, 0);
        for (int j = 1; j <= n; j++)
            put_desc(j, 32'h1, j, (j == n) ? (loop_back ? 1 : 0) : j + 1);
    endtask

    task automatic ref_count(output int n, output bit err);
        logic [31:0] p = exp_head;
        n = 0;
        while (p != exp_term && n < MAXW) begin
            p = rw(p + 16);
            n++;
        end
        err = (p != exp_term);
    endtask

    task automatic do_deq(input logic [3:0] op, input logic [1:0] b, input string req);
        logic [31:0] w = rw(exp_head);
        bit empty = (exp_head == exp_term);
        bit pass = (op == OP_DEQ_ANY) || (op == OP_DEQ_EQ && w[1:0] == b) ||
                   (op == OP_DEQ_NE && w[1:0] != b);
        logic [31:0] nh = rw(rw(exp_head + 8) + 16);
        run_cmd(op, 32'd0, b);
        if (empty || !pass) begin
            chk(req, {31'd0, res_null}, 32'd1);
        end else begin
            chk(req, {31'd0, res_null}, 32'd0);
            chk(req, res_addr, exp_head);
            exp_head = nh;
        end
        probe_head(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        int nd, n, r0;
        bit e;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", {31'd0, cmd_ready}, 32'd1);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        probe_head("R1 empty after reset");

        // R6: empty queue operations
        r0 = nreq;
        run_cmd(OP_DEQ_ANY, 32'd0, 2'd0);
        chk("R6 null", {31'd0, res_null}, 32'd1);
        run_cmd(OP_TEST_OWN, 32'd0, 2'd0);
        chk("R6 test null", {31'd0, res_null}, 32'd1);
        chk("R6 no access", 32'(nreq - r0), 32'd0);
        probe_head("R6 head kept");

        // R10: undefined opcode
        run_cmd(4'd12, 32'd0, 2'd0);
        chk("R10 undefined op", {31'd0, res_null}, 32'd1);

        // R4 / R5 directed: three-descriptor packet owned by hardware
        put_desc(0, 32'h0, 0, 0);
        put_desc(1, 32'h0300_0001, 3, 2);
        put_desc(2, 32'h0000_0001, 3, 3);
        put_desc(3, 32'h0100_0001, 3, 4);
        put_desc(4, 32'h0000_0000, 4, 0);
        set_queue(dadr(1), dadr(0));
        probe_head("R2 set head");
        do_deq(OP_DEQ_NE, 2'd1, "R5 ne blocked");
        do_deq(OP_DEQ_EQ, 2'd0, "R5 eq blocked");
        run_cmd(OP_TEST_OWN, 32'd0, 2'd1);
        chk("R3 own", {30'd0, res_own}, 32'd1);
        chk("R3 flag", {31'd0, res_flag}, 32'd1);
        do_deq(OP_DEQ_EQ, 2'd1, "R5 eq pass");
        chk("R4 skip packet", exp_head, dadr(4));
        do_deq(OP_DEQ_ANY, 2'd0, "R4 last");
        do_deq(OP_DEQ_ANY, 2'd0, "R6 now empty");

        // R7: re-arm keeps upper bits
        wr(dadr(5), 32'hFFFF_FFFE);
        run_cmd(OP_REARM, dadr(5), 2'd0);
        chk("R7 addr", res_addr, dadr(5));
        chk("R7 all ones", rw(dadr(5)), 32'hFFFF_FFFD);
        wr(dadr(5), 32'h1234_5672);
        run_cmd(OP_REARM, dadr(5), 2'd0);
        chk("R7 pattern", rw(dadr(5)), 32'h1234_5671);

        // R8 / R9: count boundaries
        build_linear(MAXW, 1'b0);
        set_queue(dadr(1), dadr(0));
        run_cmd(OP_COUNT, 32'd0, 2'd0);
        chk("R8 full count", 32'(res_count), 32'(MAXW));
        chk("R8 no err", {31'd0, res_err}, 32'd0);
        build_linear(MAXW + 1, 1'b0);
        run_cmd(OP_COUNT, 32'd0, 2'd0);
        chk("R9 over count", 32'(res_count), 32'(MAXW));
        chk("R9 err", {31'd0, res_err}, 32'd1);
        build_linear(5, 1'b1);
        run_cmd(OP_COUNT, 32'd0, 2'd0);
        chk("R9 loop err", {31'd0, res_err}, 32'd1);
        set_queue(dadr(0), dadr(0));
        run_cmd(OP_COUNT, 32'd0, 2'd0);
        chk("R8 empty count", 32'(res_count), 32'd0);

        // random rounds
        for (int round = 0; round < 25; round++) begin
            build_rand(nd);
            set_queue(dadr(1), dadr(0));
            for (int s = 0; s < 12; s++) begin
                int sel = int'($urandom % 7);
                logic [1:0] b = 2'($urandom % 3);
                case (sel)
                    0: probe_head("R2 random empty");
                    1: begin
                        logic [31:0] w = rw(exp_head);
                        run_cmd(OP_TEST_OWN, 32'd0, b);
                        if (exp_head == exp_term) begin
                            chk("R3 random null", {31'd0, res_null}, 32'd1);
                        end else begin
                            chk("R3 random own", {30'd0, res_own}, {30'd0, w[1:0]});
                            chk("R3 random flag", {31'd0, res_flag}, {31'd0, w[1:0] == b});
                        end
                    end
                    2: do_deq(OP_DEQ_ANY, b, "R4 random");
                    3: do_deq(OP_DEQ_EQ, b, "R5 random eq");
                    4: do_deq(OP_DEQ_NE, b, "R5 random ne");
                    5: begin
                        ref_count(n, e);
                        run_cmd(OP_COUNT, 32'd0, 2'd0);
                        chk("R8 random count", 32'(res_count), 32'(n));
                        chk("R8 random err", {31'd0, res_err}, {31'd0, e});
                    end
                    default: begin
                        int j = 1 + int'($urandom % nd);
                        logic [31:0] old = rw(dadr(j));
                        run_cmd(OP_REARM, dadr(j), 2'd0);
                        chk("R7 random", rw(dadr(j)), {old[31:2], 2'b01});
                    end
                endcase
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule